// File: doc/BRIEF.md
# Register-Programmed SPI Master with Loopback Channel

The block is an SPI master that software drives through four 32-bit registers. Two configuration words set the clock mode, the bit order, the target channel, the frame length in bits, the SCLK half-period and a post-frame wait. Software then feeds the frame one 32-bit word at a time through a data register. After each word it polls a status register until the engine is free, and reads the bits that were shifted in.

A frame longer than 32 bits is split into chunks. Chip select stays asserted from the first chunk to the last. Between chunks the engine parks in a state that waits for the next data word. The last channel number is not wired to a pin: it feeds MOSI straight back into the receiver, so software can test the shifting path on its own.

Top module: `spi_reg_master`

## Requirements
- R1: Register addresses: 0 = config word A (CPOL bit 31, CPHA bit 30, LSB-first bit 29, channel at bits 20:16, length in bits at 15:0); 1 = config word B (half-period in bits 31:16, wait in bits 15:0); 2 = write launches a chunk, read returns the shift-in word; 3 = status, with the state code in bits 18:16. Both config words read back as written.
- R2: The state codes are 0 idle, 1 chip-select setup, 2 shifting, 3 end of chunk, 4 waiting for the next chunk and 5 wait countdown. Only 0 and 4 count as free.
- R3: Config and data writes are ignored while the engine is not free. In idle, a data write is also ignored when the length is 0.
- R4: A frame of N bits takes ceil(N/32) data writes. Between chunks the status shows 4 and the channel's chip select stays low.
- R5: In MSB-first mode the first chunk carries ((N-1) mod 32)+1 bits and every later chunk carries 32. Each chunk is sent from its highest used bit downward, and the received bits come back right-justified.
- R6: In LSB-first mode each chunk carries min(remaining,32) bits, sent from bit 0 upward. The received bits come back left-justified, so a short chunk of n bits sits in bits 31:32-n.
- R7: SCLK sits at the CPOL level outside shifting. With CPHA=0 data is sampled on the leading edge; with CPHA=1 it is sampled on the trailing edge. All four modes work.
- R8: Each SCLK half lasts H system clocks, with H=0 treated as 1, so an n-bit chunk spends 2·n·max(H,1) clocks in state 2.
- R9: After the final chunk, chip select rises and state 5 lasts exactly W clocks before idle. With W=0 the engine goes straight to idle.
- R10: Channels 0..30 each own one active-low chip select, and at most one is low at a time. Channel 31 asserts no chip select and loops MOSI back to MISO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_addr_i |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 31 | Active-low chip selects, one per external channel |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest state to reach is the parked state between chunks of a long frame. It shows up only when the length exceeds 32 bits, and chip select must stay low there while software does nothing. The bench drives 40-bit frames in both bit orders. It stops at the chunk boundary to check the status code, the chip-select level and the partial shift-in word, and then sends the second word. A bench-side monitor follows SCLK and MOSI across the whole frame and rebuilds the 40 transmitted bits. Busy-time writes are placed while the engine sits in setup or shifting, and their effect is read back through the register interface.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NB_W   = $clog2(WORD_W) + 1;
  localparam int unsigned ST_POS = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_SHIFT = 3'd2,
    ST_END   = 3'd3,
    ST_NEXT  = 3'd4,
    ST_WAIT  = 3'd5
  } st_e;

  localparam logic [1:0] A_CFG_A = 2'd0;
  localparam logic [1:0] A_CFG_B = 2'd1;
  localparam logic [1:0] A_DATA  = 2'd2;
  localparam logic [1:0] A_STAT  = 2'd3;
endpackage

// File: rtl/spi_rm_tick.sv
module spi_rm_tick #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q, lim;

  // zero half-period behaves as one clock
  assign lim    = (half_i == '0) ? '0 : half_i - 1'b1;
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R8
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && half_i > 1) |=> !tick_o);
endmodule

// File: rtl/spi_rm_shift.sv
module spi_rm_shift #(
  parameter int unsigned W    = 32,
  parameter int unsigned NB_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [W-1:0]    word_i,
  input  logic [NB_W-1:0] nbits_i,
  input  logic            lsb_i,
  input  logic            shift_i,
  input  logic            sample_i,
  input  logic            miso_i,
  output logic            mosi_o,
  output logic [W-1:0]    rx_o
);
  logic [W-1:0]    tx_q, rx_q;
  logic [NB_W-1:0] lsh;

  // MSB-first: left-align the used bits so bit W-1 always leaves first
  assign lsh    = NB_W'(W) - nbits_i;
  assign mosi_o = lsb_i ? tx_q[0] : tx_q[W-1];
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= lsb_i ? word_i : (word_i << lsh);
      rx_q <= '0;
    end else begin
      if (shift_i)
        tx_q <= lsb_i ? (tx_q >> 1) : (tx_q << 1);
      if (sample_i)
        rx_q <= lsb_i ? {miso_i, rx_q[W-1:1]} : {rx_q[W-2:0], miso_i};
    end
  end

  // R7
  shift_sample_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_i && sample_i));
endmodule

// File: rtl/spi_rm_seq.sv
module spi_rm_seq
  import spi_rm_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned WAIT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_wr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              lsb_i,
  input  logic              cpha_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              tick_i,
  output st_e               st_o,
  output logic              run_o,
  output logic              load_o,
  output logic [NB_W-1:0]   nbits_o,
  output logic              shift_o,
  output logic              sample_o,
  output logic              act_o
);
  st_e               st_q;
  logic [LEN_W-1:0]  rem_q, rem_src;
  logic [NB_W-1:0]   nb_q, nb_new, ecnt_q;
  logic [NB_W:0]     last_e;
  logic [WAIT_W-1:0] wcnt_q;
  logic              act_q, lead, trail, last;

  assign rem_src = (st_q == ST_IDLE) ? len_i : rem_q;
  // MSB-first puts the partial chunk first, LSB-first puts it last
  always_comb begin
    if (lsb_i)
      nb_new = (rem_src > LEN_W'(WORD_W)) ? NB_W'(WORD_W) : rem_src[NB_W-1:0];
    else
      nb_new = (rem_src[NB_W-2:0] == '0) ? NB_W'(WORD_W) : {1'b0, rem_src[NB_W-2:0]};
  end

  assign load_o   = tx_wr_i && ((st_q == ST_IDLE && len_i != '0) || st_q == ST_NEXT);
  assign nbits_o  = load_o ? nb_new : nb_q;
  assign lead     = tick_i && (st_q == ST_SHIFT) && !ecnt_q[0];
  assign trail    = tick_i && (st_q == ST_SHIFT) &&  ecnt_q[0];
  assign shift_o  = cpha_i ? (lead && ecnt_q != '0) : trail;
  assign sample_o = cpha_i ? trail : lead;
  assign last_e   = {nb_q, 1'b0} - 1'b1;
  assign last     = ((NB_W+1)'(ecnt_q) == last_e);
  assign run_o    = (st_q == ST_SETUP) || (st_q == ST_SHIFT);
  assign st_o     = st_q;
  assign act_o    = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      nb_q   <= '0;
      ecnt_q <= '0;
      wcnt_q <= '0;
      act_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (load_o) begin
          rem_q  <= len_i;
          nb_q   <= nb_new;
          ecnt_q <= '0;
          st_q   <= ST_SETUP;
        end
        ST_SETUP: if (tick_i) st_q <= ST_SHIFT;
        ST_SHIFT: if (tick_i) begin
          act_q  <= ~act_q;
          ecnt_q <= ecnt_q + 1'b1;
          if (last) begin
            rem_q <= rem_q - LEN_W'(nb_q);
            st_q  <= ST_END;
          end
        end
        ST_END: begin
          if (rem_q != '0)         st_q <= ST_NEXT;
          else if (wait_i == '0)   st_q <= ST_IDLE;
          else begin
            wcnt_q <= wait_i;
            st_q   <= ST_WAIT;
          end
        end
        ST_NEXT: if (load_o) begin
          nb_q   <= nb_new;
          ecnt_q <= '0;
          st_q   <= ST_SHIFT;
        end
        ST_WAIT: begin
          wcnt_q <= wcnt_q - 1'b1;
          if (wcnt_q == 1) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  state_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q <= ST_WAIT);
  // R9
  wait_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> (wcnt_q != '0));
  // R4
  chunk_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHIFT) |-> (nb_q != '0 && nb_q <= NB_W'(WORD_W)));
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_rm_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned WAIT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [NUM_CH-2:0] cs_n_o,
  input  logic              miso_i
);
  localparam int unsigned CH_W    = $clog2(NUM_CH);
  localparam int unsigned LOOP_CH = NUM_CH - 1;

  logic [31:0]     cfg_a_q, cfg_b_q;
  logic [CH_W-1:0] act_ch_q;
  logic [31:0]     rx_w;
  logic [NB_W-1:0] nbits;
  st_e             st;
  logic free, cs_act, tick, run, load, shift, sample, act, miso_eff, tx_wr;

  logic            cfg_cpol, cfg_cpha, cfg_lsb;
  logic [CH_W-1:0] cfg_ch;

  assign cfg_cpol = cfg_a_q[31];
  assign cfg_cpha = cfg_a_q[30];
  assign cfg_lsb  = cfg_a_q[29];
  assign cfg_ch   = cfg_a_q[16 +: CH_W];

  assign free   = (st == ST_IDLE) || (st == ST_NEXT);
  assign cs_act = (st == ST_SETUP) || (st == ST_SHIFT) || (st == ST_END) || (st == ST_NEXT);
  assign tx_wr  = reg_wr_i && (reg_addr_i == A_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_a_q  <= '0;
      cfg_b_q  <= '0;
      act_ch_q <= '0;
    end else begin
      if (reg_wr_i && free && reg_addr_i == A_CFG_A) cfg_a_q <= reg_wdata_i;
      if (reg_wr_i && free && reg_addr_i == A_CFG_B) cfg_b_q <= reg_wdata_i;
      // channel frozen for the whole frame
      if (st == ST_IDLE) act_ch_q <= cfg_ch;
    end
  end

  spi_rm_tick #(.HALF_W(HALF_W)) i_tick (
    .clk_i, .rst_ni,
    .run_i  (run),
    .half_i (cfg_b_q[16 +: HALF_W]),
    .tick_o (tick)
  );

  spi_rm_seq #(.LEN_W(LEN_W), .WAIT_W(WAIT_W)) i_seq (
    .clk_i, .rst_ni,
    .tx_wr_i  (tx_wr),
    .len_i    (cfg_a_q[LEN_W-1:0]),
    .lsb_i    (cfg_lsb),
    .cpha_i   (cfg_cpha),
    .wait_i   (cfg_b_q[WAIT_W-1:0]),
    .tick_i   (tick),
    .st_o     (st),
    .run_o    (run),
    .load_o   (load),
    .nbits_o  (nbits),
    .shift_o  (shift),
    .sample_o (sample),
    .act_o    (act)
  );

  assign miso_eff = (act_ch_q == CH_W'(LOOP_CH)) ? mosi_o : miso_i;

  spi_rm_shift #(.W(WORD_W), .NB_W(NB_W)) i_shift (
    .clk_i, .rst_ni,
    .load_i   (load),
    .word_i   (reg_wdata_i),
    .nbits_i  (nbits),
    .lsb_i    (cfg_lsb),
    .shift_i  (shift),
    .sample_i (sample),
    .miso_i   (miso_eff),
    .mosi_o   (mosi_o),
    .rx_o     (rx_w)
  );

  assign sclk_o = cfg_cpol ^ act;

  for (genvar g = 0; g < NUM_CH - 1; g++) begin : g_cs
    assign cs_n_o[g] = !(cs_act && (act_ch_q == CH_W'(g)));
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CFG_A: reg_rdata_o = cfg_a_q;
      A_CFG_B: reg_rdata_o = cfg_b_q;
      A_DATA:  reg_rdata_o = rx_w;
      default: reg_rdata_o = 32'(st) << ST_POS;
    endcase
  end

  // R10
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  // R7
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_SHIFT) |-> (sclk_o == cfg_cpol));
  // R3
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !free && reg_addr_i == A_CFG_A) |=> $stable(cfg_a_q));
  // R9
  wait_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WAIT) |-> (&cs_n_o));
endmodule

// File: tb/test_spi_reg_master.sv
`timescale 1ns/1ps
module test_spi_reg_master;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        sclk_o, mosi_o;
  logic [30:0] cs_n_o;
  logic        miso_i = 1'b0;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  spi_reg_master i_spi_reg_master (.*);

  // stimulus: {config A, config B, data}, all on loopback channel 31
  localparam logic [95:0] VEC [8] = '{
    {32'h001F0008, 32'h0004000C, 32'h000000AA},
    {32'h401F000C, 32'h00020001, 32'h00000ABC},
    {32'h801F0010, 32'h00010000, 32'h00FF1234},
    {32'hC01F0020, 32'h00000002, 32'hDEADBEEF},
    {32'h201F0008, 32'h00030005, 32'h000000A5},
    {32'hE01F0014, 32'h00020000, 32'h0009ABCD},
    {32'h601F0020, 32'h00010003, 32'h13579BDF},
    {32'hA01F0005, 32'h00020001, 32'h00000016}
  };

  logic        mon_en = 1'b0;
  int          mon_cnt = 0;
  logic [63:0] mon_sh = '0;
  always @(posedge sclk_o) if (mon_en) begin
    mon_cnt++;
    mon_sh = {mon_sh[62:0], mosi_o};
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic chunk(input logic [31:0] d, output logic [31:0] rx,
                       output int n2, output int n5, output bit cs_low);
    logic [31:0] s;
    bit done;
    n2 = 0; n5 = 0; cs_low = 0;
    wr(2'd2, d);
    do begin
      rd(2'd3, s);
      if (s[18:16] == 3'd2) n2++;
      if (s[18:16] == 3'd5) n5++;
      if (cs_n_o != '1) cs_low = 1;
      done = (s[18:16] == 3'd0) || (s[18:16] == 3'd4);
      if (!done) @(negedge clk_i);
    end while (!done);
    rd(2'd2, rx);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s, rx, ca;
    int n2, n5;
    bit csl;

    // reset state
    repeat (3) @(negedge clk_i);
    rd(2'd3, s);  check(s == 0, "R2", "reset status", s, 0);
    check(cs_n_o == '1, "R10", "reset cs", cs_n_o, 31'h7FFFFFFF);
    check(sclk_o == 0, "R7", "reset sclk", sclk_o, 0);
    rd(2'd2, s);  check(s == 0, "R1", "reset rx", s, 0);
    rst_ni = 1'b1;

    // table walk over modes, orders and timings
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a, b, d;
      logic [63:0] mask, exp;
      int len, h;
      {a, b, d} = VEC[i];
      len  = int'(a[15:0]);
      h    = (b[31:16] == 0) ? 1 : int'(b[31:16]);
      mask = (64'd1 << len) - 1;
      exp  = a[29] ? (((64'(d) & mask) << (32 - len)) & 64'hFFFFFFFF) : (64'(d) & mask);
      wr(2'd0, a); wr(2'd1, b);
      rd(2'd0, s); check(s == a, "R1", "cfg A readback", s, a);
      chunk(d, rx, n2, n5, csl);
      check(64'(rx) == exp, a[29] ? "R6" : "R5", "loopback data (R7 mode)", rx, exp);
      check(n2 == 2 * len * h, "R8", "shift duration", n2, 2 * len * h);
      check(n5 == int'(b[15:0]), "R9", "wait duration", n5, b[15:0]);
      check(!csl, "R10", "loopback asserts no cs", csl, 0);
    end

    // R7 idle level follows CPOL
    wr(2'd0, 32'h801F0008);
    @(negedge clk_i); check(sclk_o == 1, "R7", "idle sclk cpol=1", sclk_o, 1);
    wr(2'd0, 32'h001F0008);
    @(negedge clk_i); check(sclk_o == 0, "R7", "idle sclk cpol=0", sclk_o, 0);

    // R3 zero length ignored
    wr(2'd0, 32'h001F0000);
    wr(2'd2, 32'h12345678);
    rd(2'd3, s); check(s[18:16] == 0, "R3", "zero length status", s[18:16], 0);
    check(cs_n_o == '1, "R3", "zero length cs", cs_n_o, 31'h7FFFFFFF);

    // R3 writes while busy ignored
    ca = 32'h001F0010;
    wr(2'd0, ca); wr(2'd1, 32'h00040000);
    wr(2'd2, 32'h0000BEEF);
    wr(2'd0, 32'h00000005);
    wr(2'd2, 32'h0000FFFF);
    rd(2'd0, s); check(s == ca, "R3", "cfg write while busy", s, ca);
    do begin @(negedge clk_i); rd(2'd3, s); end while (s[18:16] != 0);
    rd(2'd2, rx); check(rx == 32'hBEEF, "R3", "data write while busy", rx, 32'hBEEF);

    // R4 R5 40-bit MSB-first frame on external channel 3
    miso_i = 1'b1;
    wr(2'd0, 32'h00030028); wr(2'd1, 32'h00020003);
    mon_cnt = 0; mon_sh = '0; mon_en = 1'b1;
    chunk(32'h000000C3, rx, n2, n5, csl);
    check(rx == 32'hFF, "R5", "first partial chunk rx", rx, 32'hFF);
    rd(2'd3, s); check(s[18:16] == 4, "R4", "parked between chunks", s[18:16], 4);
    check(cs_n_o == 31'h7FFFFFF7, "R4", "cs held between chunks", cs_n_o, 31'h7FFFFFF7);
    chunk(32'h12345678, rx, n2, n5, csl);
    mon_en = 1'b0;
    check(rx == 32'hFFFFFFFF, "R5", "second chunk rx", rx, 32'hFFFFFFFF);
    check(mon_cnt == 40, "R4", "sclk leading edges", mon_cnt, 40);
    check(mon_sh[39:0] == 40'hC312345678, "R5", "mosi bit stream", mon_sh[39:0], 40'hC312345678);
    check(n5 == 3, "R9", "wait after frame", n5, 3);
    check(cs_n_o == '1, "R9", "cs released", cs_n_o, 31'h7FFFFFFF);
    miso_i = 1'b0;

    // R6 40-bit LSB-first frame on loopback, no wait
    wr(2'd0, 32'h201F0028); wr(2'd1, 32'h00010000);
    chunk(32'h89ABCDEF, rx, n2, n5, csl);
    check(rx == 32'h89ABCDEF, "R6", "first full chunk rx", rx, 32'h89ABCDEF);
    rd(2'd3, s); check(s[18:16] == 4, "R4", "lsb parked", s[18:16], 4);
    chunk(32'h0000005A, rx, n2, n5, csl);
    check(rx == 32'h5A000000, "R6", "final chunk left aligned", rx, 32'h5A000000);
    check(n5 == 0, "R9", "zero wait", n5, 0);
    rd(2'd3, s); check(s[18:16] == 0, "R9", "idle after zero wait", s[18:16], 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule